// File: doc/BRIEF.md
# I2C Master Start-Condition Sequencer

This block produces the opening START condition for an I2C bus master. Software writes a command word with its start bit set. The block looks at the two bus lines. If both are idle-high, it loads a 7-bit baud down-counter and lets one period run out. It then pulls SDA low while SCL stays released, which forms the START. A second full period follows. At its end the block clears the start bit, raises a completion flag, and keeps SDA held low, ready for the first data bit.

Both lines reach the block through two-flop synchronizers. The lines are checked at the moment of the request, on every clock of the first period for SCL, and at the first timeout for SDA. A low line at any of these checks counts as a bus collision. The block then drops the start, releases SDA and returns to idle.

While a start is pending, the block keeps other commands from queueing behind it. Command-word writes are ignored. A write to the transmit buffer is discarded and sets a write-collision flag.

Top module: `i2c_start_seq`

## Requirements
- R1: A command write with bit 0 (start) set, made while no start is pending, begins a sequence. The counter loads the reload value one clock after the write, provided both synchronized lines are high at that point.
- R2: The first period lasts reload+1 clocks. SDA drive-low asserts reload+2 clocks after the start write. Flag bit 0 (start detected) sets on the same clock. The SCL drive-low output is never asserted.
- R3: A second period of reload+1 clocks follows. At its end command bit 0 clears and flag bit 1 (done) sets. SDA drive-low stays asserted after completion.
- R4: If either synchronized line is low when the pending start is first examined, flag bit 2 (bus collision) sets, command bit 0 clears, and no line is driven.
- R5: SCL low on any clock of the first period, or SDA low when the first period expires, aborts the sequence. The abort sets flag bit 2, clears command bit 0 and releases SDA.
- R6: A transmit-buffer write while command bit 0 is set leaves the buffer unchanged and sets flag bit 3 (write collision). At any other time the buffer loads the written byte.
- R7: Command-word writes (all 5 bits) are ignored while command bit 0 is set.
- R8: Flags stay set until a 1 is written to the matching bit of the clear input. If a flag sets and clears on the same clock, the set wins.
- R9: After reset the command word, buffer and flags are zero, and neither line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command-word write strobe |
| cmd_wdata | input | 5 | Command word; bit 0 is start |
| cmd_q | output | 5 | Command word readback |
| reload | input | 7 | Baud counter reload value |
| txb_we | input | 1 | Transmit buffer write strobe |
| txb_wdata | input | 8 | Transmit buffer write data |
| txb_q | output | 8 | Transmit buffer contents |
| flag_clr | input | 4 | Write-one-to-clear strobes for the flags |
| flags | output | 4 | {write collision, bus collision, done, start detected} |
| sda_in | input | 1 | Sampled SDA line |
| scl_in | input | 1 | Sampled SCL line |
| sda_drive_low | output | 1 | Open-drain pull-down enable for SDA |
| scl_drive_low | output | 1 | Open-drain pull-down enable for SCL |

## Verification
The hardest cases to reach are the aborts in the middle of a sequence. SCL falling inside the first period must be told apart from SDA falling and then recovering before the timeout, and both depend on where the synchronizer delay puts the edge. The bench drives the external lines as open-drain wires, ANDed with the block's own pull-downs. It pulls a line low at chosen clock offsets after the start write, once for a short pulse and once across the timeout. A behavioural model that carries its own delay queue then decides which of the two cases occurred.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_HOLD = 2'd2
    } seq_st_t;

    typedef struct packed {
        logic wcol;
        logic bcol;
        logic done;
        logic sdet;
    } flag_vec_t;

    localparam int FLAG_N    = 4;
    localparam int CMD_W     = 5;
    localparam int CMD_START = 0;

    function automatic logic lines_idle(input logic sda, input logic scl);
        return sda & scl;
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '1;
        else     stage_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '1;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/i2cs_brg.sv
module i2cs_brg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         run,
    input  logic [W-1:0] reload,
    output logic         timeout
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                      cnt_q <= '0;
        else if (load)                cnt_q <= reload;
        else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign timeout = run && (cnt_q == '0);

    // R1
    brg_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt_q == $past(reload));
endmodule

// File: rtl/i2cs_flags.sv
module i2cs_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr) | set;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R8
        flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (q[i] && !clr[i]) |=> q[i]);
    end
endmodule

// File: rtl/i2c_start_seq.sv
module i2c_start_seq
    import i2cs_pkg::*;
#(
    parameter int RELOAD_W = 7,
    parameter int DATA_W   = 8,
    parameter int SYNC_N   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_we,
    input  logic [CMD_W-1:0]    cmd_wdata,
    output logic [CMD_W-1:0]    cmd_q,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                txb_we,
    input  logic [DATA_W-1:0]   txb_wdata,
    output logic [DATA_W-1:0]   txb_q,
    input  logic [FLAG_N-1:0]   flag_clr,
    output logic [FLAG_N-1:0]   flags,
    input  logic                sda_in,
    input  logic                scl_in,
    output logic                sda_drive_low,
    output logic                scl_drive_low
);
    seq_st_t   st_q, st_d;
    logic      sda_low_q, sda_low_d;
    logic      brg_load, brg_run, brg_tmo;
    logic      coll_ev, done_ev, sdet_ev;
    logic      pending;
    logic      sda_s, scl_s;
    logic [1:0] sync_q;
    flag_vec_t flag_set;

    assign pending = cmd_q[CMD_START];

    i2cs_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   (sync_q)
    );
    assign sda_s = sync_q[0];
    assign scl_s = sync_q[1];

    assign brg_run = (st_q != ST_IDLE);

    i2cs_brg #(.W(RELOAD_W)) u_brg (
        .clk     (clk),
        .rst     (rst),
        .load    (brg_load),
        .run     (brg_run),
        .reload  (reload),
        .timeout (brg_tmo)
    );

    always_comb begin
        st_d      = st_q;
        sda_low_d = sda_low_q;
        brg_load  = 1'b0;
        coll_ev   = 1'b0;
        done_ev   = 1'b0;
        sdet_ev   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (pending) begin
                    if (lines_idle(sda_s, scl_s)) begin
                        brg_load = 1'b1;
                        st_d     = ST_LEAD;
                    end else begin
                        coll_ev = 1'b1;
                    end
                end
            end
            ST_LEAD: begin
                if (!scl_s) begin
                    coll_ev = 1'b1;
                end else if (brg_tmo) begin
                    if (sda_s) begin
                        sda_low_d = 1'b1;
                        sdet_ev   = 1'b1;
                        brg_load  = 1'b1;
                        st_d      = ST_HOLD;
                    end else begin
                        coll_ev = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (brg_tmo) begin
                    done_ev = 1'b1;
                    st_d    = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
        if (coll_ev) begin
            st_d      = ST_IDLE;
            sda_low_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            sda_low_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            sda_low_q <= sda_low_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (coll_ev || done_ev) begin
            cmd_q[CMD_START] <= 1'b0;
        end else if (cmd_we && !pending) begin
            cmd_q <= cmd_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                     txb_q <= '0;
        else if (txb_we && !pending) txb_q <= txb_wdata;
    end

    always_comb begin
        flag_set      = '0;
        flag_set.sdet = sdet_ev;
        flag_set.done = done_ev;
        flag_set.bcol = coll_ev;
        flag_set.wcol = txb_we && pending;
    end

    i2cs_flags #(.N(FLAG_N)) u_flags (
        .clk (clk),
        .rst (rst),
        .set (flag_set),
        .clr (flag_clr),
        .q   (flags)
    );

    assign sda_drive_low = sda_low_q;
    assign scl_drive_low = 1'b0;

    // R7
    cmd_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (pending && cmd_we) |=> cmd_q[CMD_W-1:1] == $past(cmd_q[CMD_W-1:1]));

    // R6
    txb_wcol_chk: assert property (@(posedge clk) disable iff (rst)
        (pending && txb_we) |=> (txb_q == $past(txb_q)) && flags[3]);

    // R2
    sdet_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> flags[0]);

    // R4
    coll_abort_chk: assert property (@(posedge clk) disable iff (rst)
        coll_ev |=> !sda_drive_low && flags[2] && !cmd_q[CMD_START]);

    // R3
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done_ev |=> !cmd_q[CMD_START] && flags[1] && sda_drive_low);
endmodule

// File: tb/i2c_start_seq_bench.sv
`timescale 1ns/1ps
module i2c_start_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_we = 1'b0;
    logic [4:0] cmd_wdata = '0;
    logic [4:0] cmd_q;
    logic [6:0] reload = 7'd3;
    logic       txb_we = 1'b0;
    logic [7:0] txb_wdata = '0;
    logic [7:0] txb_q;
    logic [3:0] flag_clr = '0;
    logic [3:0] flags;
    logic       ext_sda = 1'b1, ext_scl = 1'b1;
    logic       sda_drive_low, scl_drive_low;
    logic       sda_line, scl_line;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    assign sda_line = ext_sda & ~sda_drive_low;
    assign scl_line = ext_scl & ~scl_drive_low;

    always #2.5 clk = ~clk;

    i2c_start_seq u_i2c_start_seq (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_q(cmd_q),
        .reload(reload), .txb_we(txb_we), .txb_wdata(txb_wdata), .txb_q(txb_q),
        .flag_clr(flag_clr), .flags(flags), .sda_in(sda_line), .scl_in(scl_line),
        .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [4:0] m_cmd;
    logic [7:0] m_txb;
    logic [3:0] m_flags;
    logic       m_sda_low;
    int         m_state, m_cnt;
    logic       sda_dly[$], scl_dly[$];

    always @(posedge clk) begin
        if (rst) begin
            m_cmd = '0; m_txb = '0; m_flags = '0; m_sda_low = 1'b0;
            m_state = 0; m_cnt = 0;
            sda_dly = '{1'b1, 1'b1};
            scl_dly = '{1'b1, 1'b1};
        end else begin
            logic s_sda, s_scl, pend, coll;
            logic [3:0] setv;
            logic line_sda;
            line_sda = ext_sda & ~m_sda_low;
            s_sda = sda_dly[0];
            s_scl = scl_dly[0];
            pend = m_cmd[0];
            coll = 1'b0;
            setv = '0;
            if (m_state == 0) begin
                if (pend) begin
                    if (s_sda && s_scl) begin m_state = 1; m_cnt = reload; end
                    else coll = 1'b1;
                end
            end else if (m_state == 1) begin
                if (!s_scl) coll = 1'b1;
                else if (m_cnt == 0) begin
                    if (s_sda) begin
                        m_sda_low = 1'b1; setv[0] = 1'b1; m_cnt = reload; m_state = 2;
                    end else coll = 1'b1;
                end else m_cnt--;
            end else begin
                if (m_cnt == 0) begin
                    m_cmd[0] = 1'b0; setv[1] = 1'b1; m_state = 0;
                end else m_cnt--;
            end
            if (coll) begin
                setv[2] = 1'b1; m_cmd[0] = 1'b0; m_sda_low = 1'b0; m_state = 0;
            end
            if (cmd_we && !pend) m_cmd = cmd_wdata;
            if (txb_we) begin
                if (pend) setv[3] = 1'b1;
                else m_txb = txb_wdata;
            end
            m_flags = (m_flags & ~flag_clr) | setv;
            void'(sda_dly.pop_front()); sda_dly.push_back(line_sda);
            void'(scl_dly.pop_front()); scl_dly.push_back(ext_scl);
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R7 cmd_q", cmd_q, m_cmd);
            chk("R6 txb_q", txb_q, m_txb);
            chk("R8 flags", flags, m_flags);
            chk("R2 sda_drive_low", sda_drive_low, m_sda_low);
            chk("R2 scl_drive_low", scl_drive_low, 1'b0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=60000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick(); @(posedge clk); @(negedge clk); endtask
    task automatic do_reset();
        rst = 1'b1; ext_sda = 1'b1; ext_scl = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
    endtask
    task automatic wr_cmd(input logic [4:0] v);
        cmd_we = 1'b1; cmd_wdata = v; tick(); cmd_we = 1'b0;
    endtask
    task automatic wr_txb(input logic [7:0] v);
        txb_we = 1'b1; txb_wdata = v; tick(); txb_we = 1'b0;
    endtask

    task automatic timed_start(input int r);
        int n, n2;
        reload = r[6:0];
        wr_cmd(5'h01);
        n = 0;
        while (!sda_drive_low && n < 300) begin tick(); n++; end
        chk("R1/R2 clocks to SDA low", n, r + 2);
        chk("R2 start detected flag", flags[0], 1'b1);
        n2 = 0;
        while (!flags[1] && n2 < 300) begin tick(); n2++; end
        chk("R3 clocks to done", n2, r + 1);
        chk("R3 start bit cleared", cmd_q[0], 1'b0);
        repeat (5) tick();
        chk("R3 SDA held low", sda_drive_low, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        // R9 reset state
        chk("R9 cmd_q", cmd_q, 5'h00);
        chk("R9 txb_q", txb_q, 8'h00);
        chk("R9 flags", flags, 4'h0);
        chk("R9 drives", {sda_drive_low, scl_drive_low}, 2'b00);

        tick();
        // R6 idle write loads
        wr_txb(8'h3C);
        chk("R6 idle load", txb_q, 8'h3C);
        chk("R6 no wcol", flags[3], 1'b0);

        timed_start(3);

        do_reset();
        timed_start(0);

        do_reset();
        timed_start(17);

        // R6 R7 R8 mid-sequence writes
        do_reset();
        wr_txb(8'h5A);
        reload = 7'd12;
        wr_cmd(5'h01);
        tick();
        wr_txb(8'hC3);
        chk("R6 buffer kept", txb_q, 8'h5A);
        chk("R6 wcol set", flags[3], 1'b1);
        txb_we = 1'b1; txb_wdata = 8'h11; flag_clr = 4'h8; tick();
        txb_we = 1'b0; flag_clr = 4'h0;
        chk("R8 set beats clear", flags[3], 1'b1);
        wr_cmd(5'h1E);
        chk("R7 write ignored", cmd_q, 5'h01);
        repeat (40) tick();
        chk("R7 cmd after done", cmd_q, 5'h00);
        chk("R8 flags sticky", flags, 4'hB);
        flag_clr = 4'h5; tick(); flag_clr = 4'h0;
        chk("R8 w1c partial", flags, 4'hA);
        wr_cmd(5'h1C);
        chk("R7 idle write accepted", cmd_q, 5'h1C);

        // R4 line low at request
        do_reset();
        ext_sda = 1'b0;
        repeat (3) tick();
        wr_cmd(5'h01);
        repeat (2) tick();
        chk("R4 bcol flag", flags[2], 1'b1);
        chk("R4 start dropped", cmd_q[0], 1'b0);
        chk("R4 no drive", sda_drive_low, 1'b0);
        ext_sda = 1'b1;

        do_reset();
        ext_scl = 1'b0;
        repeat (3) tick();
        wr_cmd(5'h01);
        repeat (2) tick();
        chk("R4 bcol on SCL low", flags[2], 1'b1);
        ext_scl = 1'b1;

        // R5 SCL pulse low during first period
        do_reset();
        reload = 7'd8;
        wr_cmd(5'h01);
        repeat (2) tick();
        ext_scl = 1'b0; tick(); ext_scl = 1'b1;
        repeat (20) tick();
        chk("R5 bcol on SCL", flags[2], 1'b1);
        chk("R5 no start", flags[0], 1'b0);
        chk("R5 SDA released", sda_drive_low, 1'b0);

        // R5 SDA short dip inside period: no collision
        do_reset();
        reload = 7'd10;
        wr_cmd(5'h01);
        repeat (2) tick();
        ext_sda = 1'b0; repeat (2) tick(); ext_sda = 1'b1;
        repeat (30) tick();
        chk("R5 short SDA dip tolerated", flags[2:0], 3'b011);

        // R5 SDA low across timeout
        do_reset();
        reload = 7'd6;
        wr_cmd(5'h01);
        repeat (2) tick();
        ext_sda = 1'b0;
        repeat (12) tick();
        ext_sda = 1'b1;
        repeat (4) tick();
        chk("R5 bcol on SDA", flags[2], 1'b1);
        chk("R5 no detect", flags[0], 1'b0);
        chk("R5 SDA free", sda_drive_low, 1'b0);

        // R4 restart while SDA still held after a completed start
        do_reset();
        timed_start(2);
        wr_cmd(5'h01);
        repeat (3) tick();
        chk("R4 restart sees SDA low", flags[2], 1'b1);
        chk("R4 released", sda_drive_low, 1'b0);

        repeat (4) tick();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule